// File: doc/BRIEF.md
# Random Memory Traffic Tester

This block is a self-checking load and store generator. It sits on the request side of a memory path and issues pseudo-random single-byte reads and writes into a small address window. A 32-bit LFSR, seeded per instance, chooses the access type, the cacheability hint, the write data and the target block. The block offset always equals the tester's own lane number. Several testers can therefore share one window without ever touching each other's bytes.

The tester keeps a shadow copy of its own lane of every block. Each request in flight sits in a small table that records the address and the value expected back. A new access whose address is already in the table is dropped for that cycle, which removes any need for an ordering checker. Every read response is compared against the recorded value. A response whose address is not in the table is flagged. Reaching a configured number of completed reads ends the run. Progress is reported by a one-cycle pulse, and a counter exposes how long the memory side has gone without answering.

Top module: `mem_traffic_tester`

## Requirements
- R1: While reset is held, req_valid, done (with cfg_max_reads nonzero), progress, err_mismatch, err_orphan and idle_cycles are all zero.
- R2: An access is a read when a draw in 0..99 is below cfg_read_pct (req_write=0), otherwise a write (req_write=1); cfg_read_pct=100 gives only reads and 0 only writes.
- R3: Every request address has its low log2(BLK_BYTES) bits equal to TESTER_ID.
- R4: No request is issued to an address that already has one in flight, and at most SLOTS requests are in flight; when the table is full, issuing stops.
- R5: Once req_valid is high it stays high, with address, type, data and cacheability unchanged, until req_ready is seen.
- R6: A read response whose data differs from the last value this tester wrote to that address (zero if never written) sets err_mismatch, which stays set; err_addr latches the address of the first error of either kind.
- R7: A response whose address has no request in flight sets err_orphan, which stays set, and it latches err_addr if no earlier error exists.
- R8: done is high once the number of completed reads reaches cfg_max_reads; after that, no new request is started.
- R9: progress pulses for one cycle on every cfg_progress_every-th completed read; a value of 0 selects an interval of 1000.
- R10: req_uncached is set when a second draw in 0..99 is below cfg_uncached_pct: always at 100, never at 0.
- R11: idle_cycles counts the clock edges without a response, saturates, and reads zero after any edge with rsp_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_read_pct | input | 7 | Read share in percent (0..100) |
| cfg_uncached_pct | input | 7 | Uncacheable share in percent (0..100) |
| cfg_max_reads | input | CNT_W | Completed reads that end the run |
| cfg_progress_every | input | CNT_W | Reads per progress pulse, 0 means 1000 |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Byte address of the request |
| req_wdata | output | 8 | Write data |
| req_uncached | output | 1 | Uncacheable hint |
| rsp_valid | input | 1 | Response present (always taken) |
| rsp_addr | input | ADDR_W | Address being answered |
| rsp_rdata | input | 8 | Read data (ignored for writes) |
| done | output | 1 | Read target reached |
| progress | output | 1 | One-cycle progress pulse |
| err_mismatch | output | 1 | Sticky read data error |
| err_orphan | output | 1 | Sticky unexpected response error |
| err_addr | output | ADDR_W | Address of the first error |
| idle_cycles | output | CNT_W | Cycles since the last response |

## Verification
The bench plays the memory with a FIFO of accepted requests and its own byte array. It watches for a repeated in-flight address: a design that checked the table only after insertion would send a second access to a busy address. It stalls the responses so the table fills, and a wrong full test would let a fifth request out. It corrupts two read responses, and a design that latched the last error instead of the first would report the wrong err_addr. It sends a response to an address with nothing in flight, which a design without the orphan check would accept silently. It drains after done, where a design that kept issuing would hand out a second new request. A run with the progress interval at 0 shows whether the default of 1000 is applied or the pulse never comes.

// File: rtl/mem_tester_pkg.sv
package mem_tester_pkg;

    localparam int          LFSR_W    = 32;
    localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

    // Scale a random byte onto 0..99.
    function automatic logic [6:0] pct_draw(input logic [7:0] b);
        logic [14:0] prod;
        prod = 15'(b) * 15'd100;
        return prod[14:8];
    endfunction

endpackage

// File: rtl/mem_tester_lfsr.sv
module mem_tester_lfsr
    import mem_tester_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'h1D87_2B41
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state
);
    localparam logic [LFSR_W-1:0] SEED_NZ = (SEED == '0) ? LFSR_W'(1) : SEED;

    logic [LFSR_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q >> 1;
        if (st_q[0]) st_d = st_d ^ LFSR_TAPS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEED_NZ;
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/mem_tester_inflight.sv
module mem_tester_inflight #(
    parameter int SLOTS = 4,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit,
    output logic          full,
    input  logic          ins_en,
    input  logic [AW-1:0] ins_addr,
    input  logic          ins_write,
    input  logic [DW-1:0] ins_expect,
    input  logic          ret_en,
    input  logic [AW-1:0] ret_addr,
    output logic          ret_hit,
    output logic          ret_write,
    output logic [DW-1:0] ret_expect
);
    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
    } slot_t;

    slot_t [SLOTS-1:0] tab_d, tab_q;
    logic  [SLOTS-1:0] vld_v, probe_m, ret_m;
    logic  [IW-1:0]    free_idx;

    for (genvar g = 0; g < SLOTS; g++) begin : g_match
        assign vld_v[g]   = tab_q[g].vld;
        assign probe_m[g] = tab_q[g].vld && (tab_q[g].addr == probe_addr);
        assign ret_m[g]   = tab_q[g].vld && (tab_q[g].addr == ret_addr);
    end

    assign probe_hit = |probe_m;
    assign full      = &vld_v;
    assign ret_hit   = |ret_m;

    always_comb begin
        ret_write  = 1'b0;
        ret_expect = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (ret_m[i]) begin
                ret_write  = tab_q[i].wr;
                ret_expect = tab_q[i].exp;
            end
        end
    end

    always_comb begin
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!vld_v[i]) free_idx = IW'(i);
        end
    end

    always_comb begin
        tab_d = tab_q;
        if (ret_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (ret_m[i]) tab_d[i].vld = 1'b0;
            end
        end
        if (ins_en && !full) begin
            tab_d[free_idx] = '{vld: 1'b1, wr: ins_write, addr: ins_addr, exp: ins_expect};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end
endmodule

// File: rtl/mem_traffic_tester.sv
module mem_traffic_tester
    import mem_tester_pkg::*;
#(
    parameter int          ADDR_W        = 8,
    parameter int          BLK_BYTES     = 4,
    parameter int          TESTER_ID     = 0,
    parameter int          SLOTS         = 4,
    parameter int          CNT_W         = 16,
    parameter logic [31:0] SEED          = 32'h1D87_2B41,
    parameter int          PROGRESS_DFLT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        cfg_read_pct,
    input  logic [6:0]        cfg_uncached_pct,
    input  logic [CNT_W-1:0]  cfg_max_reads,
    input  logic [CNT_W-1:0]  cfg_progress_every,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_wdata,
    output logic              req_uncached,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [7:0]        rsp_rdata,
    output logic              done,
    output logic              progress,
    output logic              err_mismatch,
    output logic              err_orphan,
    output logic [ADDR_W-1:0] err_addr,
    output logic [CNT_W-1:0]  idle_cycles
);
    localparam int OFS_W = $clog2(BLK_BYTES);
    localparam int LINE_W = ADDR_W - OFS_W;
    localparam int LINES = 2 ** LINE_W;
    localparam logic [OFS_W-1:0] LANE = OFS_W'(TESTER_ID);

    typedef struct packed {
        logic                  req_vld;
        logic                  req_wr;
        logic                  req_uc;
        logic [ADDR_W-1:0]     req_addr;
        logic [7:0]            req_data;
        logic [LINES-1:0][7:0] shadow;
        logic [CNT_W-1:0]      reads_done;
        logic [CNT_W-1:0]      since_pulse;
        logic                  pulse;
        logic [CNT_W-1:0]      idle;
        logic                  mis;
        logic                  orp;
        logic [ADDR_W-1:0]     bad_addr;
    } st_t;

    st_t s_d, s_q;

    logic [LFSR_W-1:0] rnd;
    logic [ADDR_W-1:0] cand_addr;
    logic              cand_rd, cand_uc;
    logic              take, done_w;
    logic [LINE_W-1:0] req_line;
    logic [7:0]        ins_expect;
    logic [CNT_W-1:0]  n_eff;
    logic              probe_hit, tab_full, ret_hit, ret_write;
    logic [7:0]        ret_expect;

    mem_tester_lfsr #(.SEED(SEED ^ 32'(TESTER_ID))) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    assign cand_addr  = {rnd[LFSR_W-1 -: LINE_W], LANE};
    assign cand_rd    = pct_draw(rnd[7:0])  < cfg_read_pct;
    assign cand_uc    = pct_draw(rnd[15:8]) < cfg_uncached_pct;
    assign take       = s_q.req_vld && req_ready;
    assign done_w     = s_q.reads_done >= cfg_max_reads;
    assign req_line   = s_q.req_addr[ADDR_W-1:OFS_W];
    assign ins_expect = s_q.req_wr ? s_q.req_data : s_q.shadow[req_line];
    assign n_eff      = (cfg_progress_every == '0) ? CNT_W'(PROGRESS_DFLT) : cfg_progress_every;

    mem_tester_inflight #(.SLOTS(SLOTS), .AW(ADDR_W), .DW(8)) i_inflight (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_addr (cand_addr),
        .probe_hit  (probe_hit),
        .full       (tab_full),
        .ins_en     (take),
        .ins_addr   (s_q.req_addr),
        .ins_write  (s_q.req_wr),
        .ins_expect (ins_expect),
        .ret_en     (rsp_valid),
        .ret_addr   (rsp_addr),
        .ret_hit    (ret_hit),
        .ret_write  (ret_write),
        .ret_expect (ret_expect)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;

        // Handshake: shadow copy follows every accepted write.
        if (take) begin
            s_d.req_vld = 1'b0;
            if (s_q.req_wr) s_d.shadow[req_line] = s_q.req_data;
        end

        // Completion side.
        if (rsp_valid) begin
            s_d.idle = '0;
            if (ret_hit) begin
                if (!ret_write) begin
                    s_d.reads_done = s_q.reads_done + 1'b1;
                    if (s_q.since_pulse + 1'b1 >= n_eff) begin
                        s_d.pulse       = 1'b1;
                        s_d.since_pulse = '0;
                    end else begin
                        s_d.since_pulse = s_q.since_pulse + 1'b1;
                    end
                    if (rsp_rdata != ret_expect) begin
                        if (!s_q.mis && !s_q.orp) s_d.bad_addr = rsp_addr;
                        s_d.mis = 1'b1;
                    end
                end
            end else begin
                if (!s_q.mis && !s_q.orp) s_d.bad_addr = rsp_addr;
                s_d.orp = 1'b1;
            end
        end else if (s_q.idle != '1) begin
            s_d.idle = s_q.idle + 1'b1;
        end

        // Issue side: a busy address or a full table drops the draw.
        if (!s_q.req_vld && !done_w && !tab_full && !probe_hit) begin
            s_d.req_vld  = 1'b1;
            s_d.req_wr   = !cand_rd;
            s_d.req_uc   = cand_uc;
            s_d.req_addr = cand_addr;
            s_d.req_data = rnd[23:16];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_valid    = s_q.req_vld;
    assign req_write    = s_q.req_wr;
    assign req_addr     = s_q.req_addr;
    assign req_wdata    = s_q.req_data;
    assign req_uncached = s_q.req_uc;
    assign done         = done_w;
    assign progress     = s_q.pulse;
    assign err_mismatch = s_q.mis;
    assign err_orphan   = s_q.orp;
    assign err_addr     = s_q.bad_addr;
    assign idle_cycles  = s_q.idle;
endmodule

// File: rtl/mem_traffic_tester_chk.sv
module mem_traffic_tester_chk #(
    parameter int ADDR_W    = 8,
    parameter int BLK_BYTES = 4,
    parameter int TESTER_ID = 0,
    parameter int CNT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_wdata,
    input logic              req_uncached,
    input logic              rsp_valid,
    input logic              done,
    input logic              err_mismatch,
    input logic              err_orphan,
    input logic [ADDR_W-1:0] err_addr,
    input logic [CNT_W-1:0]  idle_cycles
);
    localparam int OFS_W = $clog2(BLK_BYTES);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
                                    && $stable(req_wdata) && $stable(req_uncached));

    assert_own_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[OFS_W-1:0] == OFS_W'(TESTER_ID));

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !req_valid |=> !req_valid);

    assert_mismatch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_mismatch |=> err_mismatch && $stable(err_addr));

    assert_orphan_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_orphan |=> err_orphan && $stable(err_addr));

    assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> idle_cycles == '0);
endmodule

bind mem_traffic_tester mem_traffic_tester_chk #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES),
    .TESTER_ID (TESTER_ID),
    .CNT_W     (CNT_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_uncached (req_uncached),
    .rsp_valid    (rsp_valid),
    .done         (done),
    .err_mismatch (err_mismatch),
    .err_orphan   (err_orphan),
    .err_addr     (err_addr),
    .idle_cycles  (idle_cycles)
);

// File: tb/test_mem_traffic_tester.sv
`timescale 1ns/1ps
module test_mem_traffic_tester;
    localparam int ADDR_W = 8;
    localparam int BLK    = 4;
    localparam int ID     = 2;
    localparam int SLOTS  = 4;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] cfg_read_pct = '0, cfg_uncached_pct = '0;
    logic [CNT_W-1:0] cfg_max_reads = '0, cfg_progress_every = '0;
    logic req_valid, req_write, req_uncached;
    logic req_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0] req_wdata;
    logic rsp_valid = 1'b0;
    logic [ADDR_W-1:0] rsp_addr = '0;
    logic [7:0] rsp_rdata = '0;
    logic done, progress, err_mismatch, err_orphan;
    logic [ADDR_W-1:0] err_addr;
    logic [CNT_W-1:0] idle_cycles;

    always #2.5 clk = ~clk;

    mem_traffic_tester #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK), .TESTER_ID(ID),
                         .SLOTS(SLOTS), .CNT_W(CNT_W)) i_mem_traffic_tester (
        .clk(clk), .rst_n(rst_n),
        .cfg_read_pct(cfg_read_pct), .cfg_uncached_pct(cfg_uncached_pct),
        .cfg_max_reads(cfg_max_reads), .cfg_progress_every(cfg_progress_every),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_uncached(req_uncached),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata),
        .done(done), .progress(progress), .err_mismatch(err_mismatch),
        .err_orphan(err_orphan), .err_addr(err_addr), .idle_cycles(idle_cycles)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        int                due;
    } pend_t;

    pend_t q[$];
    logic [7:0] bmem [64];
    bit inflight [256];
    int checks = 0, errors = 0, cyc = 0;
    int inflight_n, max_inflight, rd_rsp_cnt, prog_seen, acc_after_done, reads_n, writes_n;
    int ready_mode, lat, mode_rd, mode_uc, corrupt1, corrupt2, cur_max;
    bit resp_en, chk_done_en, done_seen, inj_en, hold_pend, finished;
    logic [ADDR_W-1:0] inj_addr, first_bad, h_addr;
    logic h_wr, h_uc;
    logic [7:0] h_data;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver side: record each accepted request and its expected response.
    task automatic accept();
        pend_t e;
        if (done) acc_after_done++;
        check(req_addr[1:0] == 2'(ID), "R3", "lane", req_addr[1:0], ID);
        check(!inflight[req_addr], "R4", "duplicate in flight", req_addr, 0);
        check(inflight_n < SLOTS, "R4", "table capacity", inflight_n + 1, SLOTS);
        if (mode_rd == 1) check(!req_write, "R2", "all-read type", req_write, 0);
        if (mode_rd == 2) check(req_write, "R2", "all-write type", req_write, 1);
        if (mode_uc == 1) check(req_uncached, "R10", "always uncached", req_uncached, 1);
        if (mode_uc == 2) check(!req_uncached, "R10", "never uncached", req_uncached, 0);
        if (req_write) begin
            bmem[req_addr[7:2]] = req_wdata;
            writes_n++;
        end else reads_n++;
        inflight[req_addr] = 1;
        inflight_n++;
        if (inflight_n > max_inflight) max_inflight = inflight_n;
        e.addr = req_addr; e.wr = req_write; e.due = cyc + lat;
        q.push_back(e);
    endtask

    task automatic step();
        bit rdy;
        pend_t e;
        logic [7:0] d;
        @(negedge clk);
        cyc++;
        if (progress) prog_seen++;
        if (done) done_seen = 1;
        if (chk_done_en)
            check(done == (rd_rsp_cnt >= cur_max), "R8", "done level", done, rd_rsp_cnt >= cur_max);
        if (hold_pend) begin
            check(req_valid && req_addr == h_addr && req_write == h_wr && req_wdata == h_data
                  && req_uncached == h_uc, "R5", "held request", req_addr, h_addr);
            hold_pend = 0;
        end
        rdy = (ready_mode == 0) || (ready_mode == 1 && (cyc % 3) != 0);
        if (req_valid && !rdy) begin
            hold_pend = 1; h_addr = req_addr; h_wr = req_write; h_data = req_wdata; h_uc = req_uncached;
        end
        if (req_valid && rdy) accept();
        req_ready = rdy;
        rsp_valid = 0; rsp_addr = '0; rsp_rdata = '0;
        if (inj_en) begin
            rsp_valid = 1; rsp_addr = inj_addr; inj_en = 0;
        end else if (resp_en && q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            d = 8'h00;
            if (!e.wr) begin
                rd_rsp_cnt++;
                d = bmem[e.addr[7:2]];
                if (rd_rsp_cnt == corrupt1 || rd_rsp_cnt == corrupt2) begin
                    d = d ^ 8'h5A;
                    if (rd_rsp_cnt == corrupt1) first_bad = e.addr;
                end
            end
            rsp_valid = 1; rsp_addr = e.addr; rsp_rdata = d;
            inflight[e.addr] = 0;
            inflight_n--;
        end
    endtask

    task automatic do_reset(input int rd, input int uc, input int mx, input int pe);
        @(negedge clk);
        rst_n = 0; req_ready = 0; rsp_valid = 0;
        cfg_read_pct = 7'(rd); cfg_uncached_pct = 7'(uc);
        cfg_max_reads = CNT_W'(mx); cfg_progress_every = CNT_W'(pe);
        cur_max = mx;
        q.delete();
        foreach (bmem[i]) bmem[i] = 8'h00;
        foreach (inflight[i]) inflight[i] = 0;
        inflight_n = 0; max_inflight = 0; rd_rsp_cnt = 0; prog_seen = 0; acc_after_done = 0;
        reads_n = 0; writes_n = 0; corrupt1 = -1; corrupt2 = -1; done_seen = 0;
        inj_en = 0; hold_pend = 0; first_bad = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic run_to_done(input int limit);
        for (int i = 0; i < limit && !(done_seen && q.size() == 0); i++) step();
        ready_mode = 0;
        repeat (20) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end

    initial begin
        int a, b;
        finished = 0;
        // Phase A: mixed traffic, stalls on ready, progress every 7 reads.
        ready_mode = 1; lat = 3; resp_en = 1; chk_done_en = 0; mode_rd = 0; mode_uc = 0;
        do_reset(50, 30, 40, 7);
        rst_n = 0;
        @(negedge clk);
        check(!req_valid, "R1", "reset req_valid", req_valid, 0);
        check(!done, "R1", "reset done", done, 0);
        check(!progress && !err_mismatch && !err_orphan, "R1", "reset flags",
              {progress, err_mismatch, err_orphan}, 0);
        check(idle_cycles == 0, "R1", "reset idle", idle_cycles, 0);
        rst_n = 1;
        chk_done_en = 1;
        run_to_done(5000);
        check(done, "R8", "done after mixed run", done, 1);
        check(acc_after_done <= 1, "R8", "starts after done", acc_after_done, 1);
        check(reads_n > 0 && writes_n > 0, "R2", "mixed types", reads_n, writes_n);
        check(prog_seen == rd_rsp_cnt / 7, "R9", "pulses every 7", prog_seen, rd_rsp_cnt / 7);
        check(!err_mismatch && !err_orphan, "R6", "clean data", {err_mismatch, err_orphan}, 0);

        // Phase B: reads only, always uncached, default progress interval.
        ready_mode = 0; lat = 1; mode_rd = 1; mode_uc = 1;
        do_reset(100, 100, 1003, 0);
        run_to_done(20000);
        check(done, "R8", "done after read run", done, 1);
        check(prog_seen == rd_rsp_cnt / 1000 && prog_seen == 1, "R9", "default interval 1000",
              prog_seen, 1);
        check(!err_mismatch, "R6", "zero-filled reads", err_mismatch, 0);

        // Phase C: writes only, never uncached; no reads so never done.
        mode_rd = 2; mode_uc = 2;
        do_reset(0, 0, 5, 7);
        repeat (300) step();
        check(reads_n == 0 && writes_n > 0, "R2", "write only count", reads_n, 0);
        check(!done, "R8", "no reads so not done", done, 0);
        check(prog_seen == 0, "R9", "no pulse without reads", prog_seen, 0);

        // Phase D: two corrupted read responses; first address must stay latched.
        mode_rd = 0; mode_uc = 0; lat = 2;
        do_reset(50, 0, 60, 0);
        corrupt1 = 3; corrupt2 = 6;
        run_to_done(5000);
        check(err_mismatch, "R6", "mismatch flagged", err_mismatch, 1);
        check(err_addr == first_bad, "R6", "first error address", err_addr, first_bad);
        check(!err_orphan, "R7", "no orphan", err_orphan, 0);

        // Phase E: responses withheld until the table fills.
        do_reset(50, 0, 100, 0);
        resp_en = 0;
        repeat (40) step();
        check(max_inflight == SLOTS, "R4", "table fills then stalls", max_inflight, SLOTS);
        resp_en = 1;
        repeat (40) step();
        check(!err_mismatch && !err_orphan, "R4", "drain clean", {err_mismatch, err_orphan}, 0);

        // Phase F: nothing accepted, idle counting, then an orphan response.
        ready_mode = 2;
        do_reset(50, 0, 5, 0);
        step();
        a = idle_cycles;
        repeat (5) step();
        b = idle_cycles;
        check(b - a == 5, "R11", "idle counts edges", b - a, 5);
        inj_addr = 8'h13; inj_en = 1;
        step();
        step();
        check(idle_cycles == 0, "R11", "idle cleared by response", idle_cycles, 0);
        check(err_orphan, "R7", "orphan flagged", err_orphan, 1);
        check(err_addr == 8'h13, "R7", "orphan address", err_addr, 8'h13);
        check(!err_mismatch, "R7", "orphan is not mismatch", err_mismatch, 0);
        repeat (3) step();
        check(err_orphan && err_addr == 8'h13, "R7", "orphan sticky", err_addr, 8'h13);
        summary();
    end
endmodule